// File: doc/BRIEF.md
# Grouped Interrupt Summary and End-of-Interrupt Controller

This block gathers the per-pin interrupt-status and wake-status flags of a large pin bank and reduces them to one summary bit for each group of four adjacent pins. The summary is presented as two 32-bit words. The low word carries groups 0 to 31, and the high word carries the remaining groups with its unused upper bits held at zero. An interrupt handler reads the two words, visits the four pins of each flagged group, and clears the pins it finds set.

A single upstream interrupt line is controlled by a three-state machine. In `ST_IDLE` the line is low and the machine waits for any summary bit. The transition *pending* moves it to `ST_ACTIVE`, where the line is high. The line stays high, whatever happens to the pins, until software writes the end-of-interrupt (EOI) bit of the master register. That write is the transition *eoi* into `ST_GAP`, which lasts one cycle with the line low. The machine then takes the transition *rearm* back to `ST_IDLE`. From there it goes to `ST_ACTIVE` again at once if groups are still pending. The low phase gives an edge-sensitive receiver a fresh edge.

The master register is written through a strobe and a data word. The EOI bit is bit 0 and is self-clearing. The other bits hold whatever was last written, so surrounding logic can decode them.

Top module: `grp_irq_summary`

## Requirements
- R1: Summary bit k is the OR of interrupt status and wake status over pins 4k to 4k+3. It shows the pin values sampled at the previous clock edge.
- R2: Groups 0 to 31 appear in bits 0 to 31 of the low word. Groups 32 to 45 appear in bits 0 to 13 of the high word.
- R3: Bits 14 to 31 of the high word always read as 0.
- R4: After reset, both summary words are 0, the interrupt line is low and the master readback is 0.
- R5: From idle, the interrupt line rises one cycle after the summary becomes nonzero, which is two cycles after a pin status is set.
- R6: Once the line is high it stays high until a master write with bit 0 set. This holds even if every pin clears, and a master write with bit 0 clear does not lower it.
- R7: A master write with bit 0 set while the line is high lowers the line in the next cycle. The line then stays low for at least two cycles.
- R8: If any summary bit is still set after an EOI, the line rises again two cycles after it dropped.
- R9: If the summary is zero after an EOI, the line stays low until a new pin status appears.
- R10: Master readback bit 0 always reads 0. Bits 31 to 1 return the last value written, one cycle after the write.
- R11: A master write with bit 0 set while the line is low changes nothing on the line. A later event still raises the line two cycles after its pin status is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_int_sts | input | 184 | Per-pin interrupt status |
| pin_wake_sts | input | 184 | Per-pin wake status |
| mst_wr_en | input | 1 | Master register write strobe |
| mst_wr_data | input | 32 | Master register write data, bit 0 = EOI |
| sum_lo | output | 32 | Summary word for groups 0 to 31 |
| sum_hi | output | 32 | Summary word for groups 32 to 45, upper bits zero |
| mst_rd_data | output | 32 | Master register readback |
| irq_out | output | 1 | Upstream interrupt line |

## Verification
Some behaviours are checked by the assertions on every cycle:
- the line holds until an EOI and drops right after one;
- the low phase lasts at least two cycles;
- every rising edge follows a nonzero summary;
- the padding bits of the high word and the EOI readback bit stay zero;
- the first group's summary bit tracks its pins.

The bench scenarios are needed for the rest:
- the placement of groups across the word boundary;
- the exact rearm timing with events still pending, against silence with none;
- the lack of effect of an EOI written in idle;
- how the stored master bits persist across writes.

// File: rtl/grp_irq_summary_pkg.sv
package grp_irq_summary_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_GAP    = 2'd2
    } line_state_e;

endpackage

// File: rtl/grp_summary_or.sv
module grp_summary_or #(
    parameter int NUM_PINS     = 184,
    parameter int PINS_PER_GRP = 4,
    parameter int NUM_GRPS     = 46
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] int_sts,
    input  logic [NUM_PINS-1:0] wake_sts,
    output logic [NUM_GRPS-1:0] sum_q
);
    localparam int PAD_W = NUM_GRPS * PINS_PER_GRP;

    logic [PAD_W-1:0]    active;
    logic [NUM_GRPS-1:0] sum_d;

    assign active = PAD_W'(int_sts | wake_sts);

    for (genvar g = 0; g < NUM_GRPS; g++) begin : g_grp
        assign sum_d[g] = |active[g*PINS_PER_GRP +: PINS_PER_GRP];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= sum_d;
    end
endmodule

// File: rtl/grp_master_reg.sv
module grp_master_reg #(
    parameter int WORD_W  = 32,
    parameter int EOI_BIT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    output logic              eoi_pulse
);
    localparam logic [WORD_W-1:0] EOI_MASK = WORD_W'(1) << EOI_BIT;

    logic [WORD_W-1:0] store_q;

    always_ff @(posedge clk) begin
        if (!rst_n)     store_q <= '0;
        else if (wr_en) store_q <= wr_data & ~EOI_MASK;
    end

    assign rd_data   = store_q;
    assign eoi_pulse = wr_en & wr_data[EOI_BIT];
endmodule

// File: rtl/grp_irq_line_fsm.sv
module grp_irq_line_fsm
    import grp_irq_summary_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_pend,
    input  logic eoi,
    output logic irq
);
    line_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (any_pend) state_d = ST_ACTIVE;
            ST_ACTIVE: if (eoi)      state_d = ST_GAP;
            ST_GAP:                  state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_ACTIVE: irq = 1'b1;
            default:   irq = 1'b0;
        endcase
    end
endmodule

// File: rtl/grp_irq_summary.sv
module grp_irq_summary #(
    parameter int NUM_PINS     = 184,
    parameter int PINS_PER_GRP = 4,
    parameter int WORD_W       = 32,
    parameter int EOI_BIT      = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_int_sts,
    input  logic [NUM_PINS-1:0] pin_wake_sts,
    input  logic                mst_wr_en,
    input  logic [WORD_W-1:0]   mst_wr_data,
    output logic [WORD_W-1:0]   sum_lo,
    output logic [WORD_W-1:0]   sum_hi,
    output logic [WORD_W-1:0]   mst_rd_data,
    output logic                irq_out
);
    localparam int NUM_GRPS = (NUM_PINS + PINS_PER_GRP - 1) / PINS_PER_GRP;
    localparam int SUM_W    = 2 * WORD_W;

    logic [NUM_GRPS-1:0] sum_q;
    logic [SUM_W-1:0]    sum_ext;
    logic                eoi_pulse;

    grp_summary_or #(
        .NUM_PINS     (NUM_PINS),
        .PINS_PER_GRP (PINS_PER_GRP),
        .NUM_GRPS     (NUM_GRPS)
    ) u_sum (
        .clk      (clk),
        .rst_n    (rst_n),
        .int_sts  (pin_int_sts),
        .wake_sts (pin_wake_sts),
        .sum_q    (sum_q)
    );

    grp_master_reg #(
        .WORD_W  (WORD_W),
        .EOI_BIT (EOI_BIT)
    ) u_mst (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (mst_wr_en),
        .wr_data   (mst_wr_data),
        .rd_data   (mst_rd_data),
        .eoi_pulse (eoi_pulse)
    );

    grp_irq_line_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .any_pend (|sum_q),
        .eoi      (eoi_pulse),
        .irq      (irq_out)
    );

    assign sum_ext = SUM_W'(sum_q);
    assign sum_lo  = sum_ext[WORD_W-1:0];
    assign sum_hi  = sum_ext[SUM_W-1:WORD_W];
endmodule

// File: rtl/grp_irq_summary_chk.sv
module grp_irq_summary_chk #(
    parameter int NUM_PINS     = 184,
    parameter int PINS_PER_GRP = 4,
    parameter int WORD_W       = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [PINS_PER_GRP-1:0] grp0_int,
    input logic [PINS_PER_GRP-1:0] grp0_wake,
    input logic                    eoi_wr,
    input logic [WORD_W-1:0]       sum_lo,
    input logic [WORD_W-1:0]       sum_hi,
    input logic                    rd_eoi_bit,
    input logic                    irq_out
);
    localparam int NUM_GRPS = (NUM_PINS + PINS_PER_GRP - 1) / PINS_PER_GRP;
    localparam int HI_USED  = NUM_GRPS - WORD_W;

    a_r1_group0_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> sum_lo[0] == $past(|(grp0_int | grp0_wake)));

    a_r3_hi_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_hi >> HI_USED) == '0);

    a_r5_rise_needs_summary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> $past((sum_lo | sum_hi) != '0));

    a_r6_hold_until_eoi: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out && !eoi_wr |=> irq_out);

    a_r7_eoi_drops: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out && eoi_wr |=> !irq_out);

    a_r7_low_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_out) |=> !irq_out);

    a_r10_eoi_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_eoi_bit);
endmodule

bind grp_irq_summary grp_irq_summary_chk #(
    .NUM_PINS     (NUM_PINS),
    .PINS_PER_GRP (PINS_PER_GRP),
    .WORD_W       (WORD_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .grp0_int   (pin_int_sts[PINS_PER_GRP-1:0]),
    .grp0_wake  (pin_wake_sts[PINS_PER_GRP-1:0]),
    .eoi_wr     (mst_wr_en & mst_wr_data[EOI_BIT]),
    .sum_lo     (sum_lo),
    .sum_hi     (sum_hi),
    .rd_eoi_bit (mst_rd_data[EOI_BIT]),
    .irq_out    (irq_out)
);

// File: tb/grp_irq_summary_bench.sv
module grp_irq_summary_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [183:0] pin_int_sts = '0;
    logic [183:0] pin_wake_sts = '0;
    logic         mst_wr_en = 1'b0;
    logic [31:0]  mst_wr_data = '0;
    logic [31:0]  sum_lo, sum_hi, mst_rd_data;
    logic         irq_out;

    grp_irq_summary u_grp_irq_summary (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_int_sts  (pin_int_sts),
        .pin_wake_sts (pin_wake_sts),
        .mst_wr_en    (mst_wr_en),
        .mst_wr_data  (mst_wr_data),
        .sum_lo       (sum_lo),
        .sum_hi       (sum_hi),
        .mst_rd_data  (mst_rd_data),
        .irq_out      (irq_out)
    );

    always #4 clk = ~clk;

    typedef struct {
        int          cyc;
        logic [31:0] lo;
        logic [31:0] hi;
        logic        irq;
        logic [31:0] mrd;
        string       req;
    } exp_t;

    exp_t         sb[$];
    int           cyc = 0;
    int           n_checks = 0;
    int           n_fails = 0;
    bit           done = 1'b0;
    logic [183:0] m_int = '0;
    logic [183:0] m_wake = '0;
    logic [31:0]  m_mst = '0;

    always @(posedge clk) cyc++;

    function automatic logic [63:0] model_sum();
        logic [63:0] s = '0;
        for (int k = 0; k < 46; k++)
            for (int j = 0; j < 4; j++)
                if (m_int[4*k+j] || m_wake[4*k+j]) s[k] = 1'b1;
        return s;
    endfunction

    task automatic expect_in(input int dly, input logic irq_e, input string req);
        logic [63:0] s;
        exp_t e;
        s = model_sum();
        e.cyc = cyc + dly;
        e.lo  = s[31:0];
        e.hi  = s[63:32];
        e.irq = irq_e;
        e.mrd = m_mst;
        e.req = req;
        sb.push_back(e);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic apply_pins();
        pin_int_sts  = m_int;
        pin_wake_sts = m_wake;
    endtask

    task automatic start_write(input logic [31:0] d);
        mst_wr_en   = 1'b1;
        mst_wr_data = d;
        m_mst       = d & 32'hFFFF_FFFE;
    endtask

    task automatic end_write();
        mst_wr_en   = 1'b0;
        mst_wr_data = '0;
    endtask

    // Monitor: pops expected items when their cycle arrives and compares
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            while (sb.size() != 0 && sb[0].cyc <= cyc) begin
                e = sb.pop_front();
                n_checks++;
                if (e.cyc != cyc || sum_lo !== e.lo || sum_hi !== e.hi ||
                    irq_out !== e.irq || mst_rd_data !== e.mrd) begin
                    n_fails++;
                    $display("FAIL %s: lo=%h hi=%h irq=%b mrd=%h, expected lo=%h hi=%h irq=%b mrd=%h",
                             e.req, sum_lo, sum_hi, irq_out, mst_rd_data,
                             e.lo, e.hi, e.irq, e.mrd);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    // Driver
    initial begin
        tick(3);
        rst_n = 1'b1;
        expect_in(1, 1'b0, "R4 reset state");
        tick(2);

        // Single group in the low word
        m_int[5] = 1'b1; apply_pins();
        expect_in(1, 1'b0, "R1 group 1 set, line not yet up");
        expect_in(2, 1'b1, "R5 line rises");
        tick(3);

        // Pins clear but the line holds
        m_int[5] = 1'b0; apply_pins();
        expect_in(1, 1'b1, "R6 hold after clear");
        expect_in(3, 1'b1, "R6 still held");
        tick(4);

        // Word boundary and high-word groups
        m_int[127] = 1'b1; m_wake[128] = 1'b1;
        m_int[130] = 1'b1; m_wake[183] = 1'b1; apply_pins();
        expect_in(1, 1'b1, "R2 R3 boundary groups");
        tick(2);

        // EOI with groups still pending
        start_write(32'h0000_00A1);
        expect_in(1, 1'b0, "R7 R10 eoi drops line");
        expect_in(2, 1'b0, "R7 low gap");
        expect_in(3, 1'b1, "R8 rearm with pending");
        tick(1); end_write(); tick(3);

        // Clear everything, then EOI with nothing pending
        m_int = '0; m_wake = '0; apply_pins();
        expect_in(1, 1'b1, "R6 hold with empty summary");
        tick(2);
        start_write(32'h0000_0301);
        expect_in(1, 1'b0, "R7 R10 eoi, nothing pending");
        expect_in(2, 1'b0, "R9 stays low");
        expect_in(4, 1'b0, "R9 stays low");
        expect_in(6, 1'b0, "R9 stays low");
        tick(1); end_write(); tick(6);

        // EOI while idle
        start_write(32'h0000_0001);
        expect_in(1, 1'b0, "R11 eoi in idle");
        expect_in(3, 1'b0, "R11 eoi in idle");
        tick(1); end_write(); tick(3);

        // Non-EOI write stores its bits
        start_write(32'h55AA_0000);
        expect_in(1, 1'b0, "R10 stored bits");
        tick(1); end_write(); tick(1);

        // Group 0 with both status kinds, after the idle EOI
        m_int[0] = 1'b1; m_wake[0] = 1'b1; apply_pins();
        expect_in(1, 1'b0, "R1 group 0");
        expect_in(2, 1'b1, "R5 R11 rise after idle eoi");
        tick(3);

        // Write without EOI bit while active
        start_write(32'h0000_0F00);
        expect_in(1, 1'b1, "R6 R10 non-eoi write keeps line");
        expect_in(3, 1'b1, "R6 still held");
        tick(1); end_write(); tick(4);

        n_checks++;
        if (sb.size() != 0) begin
            n_fails++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule